// File: doc/BRIEF.md
# PWM Output Pin-Pair Conditioner

This block sits between a PWM duty generator and the two pads of one PWM channel, a high-side pin and a low-side pin. It turns one raw duty signal (or two, in independent mode) into the pair of pin levels. A two-bit mode field picks how the pair is derived: complementary, redundant, push-pull or independent. The pair can then be exchanged, replaced pin by pin with software override data, and replaced with fault data when a fault or current-limit flag is raised. A per-pin polarity inversion is applied as the very last step.

Each pin also has an ownership flag. It tells the pad multiplexer whether the PWM path or general-purpose I/O drives that pad. The mode, swap, polarity and ownership fields are sampled only while the module enable is low, so a running channel cannot be reconfigured by accident. The override fields can be applied either on the next clock or only on the next period-boundary strobe, so that an override never cuts a period short. All pin levels leave the block from registers.

Top module: `pwm_pin_pair_cond`

## Requirements
- R1: Mode 2'b00 (complementary): pin_hi follows gen_a and pin_lo is its inverse.
- R2: Mode 2'b01 (redundant): pin_hi and pin_lo both follow gen_a.
- R3: Mode 2'b10 (push-pull): gen_a is steered to pin_hi or pin_lo and the other pin is 0. The selector starts on pin_hi and flips on every period_stb while enable is 1. It is held on pin_hi while enable is 0.
- R4: Mode 2'b11 (independent): pin_hi follows gen_a and pin_lo follows gen_b.
- R5: own_hi and own_lo reflect cfg_own_hi and cfg_own_lo as captured (1 = PWM path drives the pad, 0 = general-purpose I/O drives it).
- R6: cfg_inv_hi=1 inverts the final pin_hi level, and cfg_inv_lo=1 inverts the final pin_lo level. Inversion is applied after every substitution.
- R7: cfg_ovr_en_hi=1 replaces the high signal with cfg_ovr_val[1]. cfg_ovr_en_lo=1 replaces the low signal with cfg_ovr_val[0].
- R8: With cfg_ovr_sync=1, the override enables and override data are captured only in a cycle with period_stb=1. With cfg_ovr_sync=0 they are captured on every clock.
- R9: With cfg_indep_flt=0, fault_in=1 forces the high signal to cfg_flt_val[1] and the low signal to cfg_flt_val[0], and climit_in has no effect.
- R10: With cfg_indep_flt=1, climit_in=1 forces only the high signal to cfg_flt_val[1], and fault_in=1 forces only the low signal to cfg_flt_val[0].
- R11: The substitution order is as follows. Mode shaping comes first, then the swap, then the override, then fault or current-limit data (which wins), then polarity.
- R12: cfg_swap=1 exchanges the high and low signals after mode shaping.
- R13: cfg_mode, cfg_swap, cfg_inv_hi, cfg_inv_lo, cfg_own_hi and cfg_own_lo are captured only while enable=0. Changes to them while enable=1 have no effect.
- R14: While rst_n is low, pin_hi, pin_lo, own_hi and own_lo are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; freezes mode, swap, polarity and ownership |
| gen_a | input | 1 | Primary raw duty signal |
| gen_b | input | 1 | Second raw duty signal (independent mode low pin) |
| period_stb | input | 1 | One-cycle period-boundary strobe |
| fault_in | input | 1 | Fault flag |
| climit_in | input | 1 | Current-limit flag |
| cfg_mode | input | 2 | Pair mode: 00 complementary, 01 redundant, 10 push-pull, 11 independent |
| cfg_swap | input | 1 | Exchange high and low signals |
| cfg_inv_hi | input | 1 | High pin active-low |
| cfg_inv_lo | input | 1 | Low pin active-low |
| cfg_own_hi | input | 1 | High pad owned by PWM path |
| cfg_own_lo | input | 1 | Low pad owned by PWM path |
| cfg_ovr_en_hi | input | 1 | High pin override enable |
| cfg_ovr_en_lo | input | 1 | Low pin override enable |
| cfg_ovr_val | input | 2 | Override data: bit 1 high pin, bit 0 low pin |
| cfg_ovr_sync | input | 1 | Apply override changes only on period_stb |
| cfg_flt_val | input | 2 | Fault data: bit 1 high pin, bit 0 low pin |
| cfg_indep_flt | input | 1 | Independent fault mode (current-limit drives high, fault drives low) |
| pin_hi | output | 1 | High-side pin level |
| pin_lo | output | 1 | Low-side pin level |
| own_hi | output | 1 | High-side pad ownership flag |
| own_lo | output | 1 | Low-side pad ownership flag |

## Verification
The generator inputs, fault and current-limit flags, fault data and fault mode reach the pins one clock edge after they are driven. The frozen configuration fields and the unsynchronised override fields pass through a capture register first, so they reach the pins two edges after they are driven. A synchronised override or a push-pull flip reaches the pins one edge after the strobe edge. The bench drives every input on a falling edge and samples on a later falling edge, after at least that many rising edges. In the vector table every entry waits two edges, which covers the slowest path a vector touches.

// File: rtl/pwm_pin_pair_cond.sv
module pwm_pin_pair_cond (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       gen_a,
  input  logic       gen_b,
  input  logic       period_stb,
  input  logic       fault_in,
  input  logic       climit_in,
  input  logic [1:0] cfg_mode,
  input  logic       cfg_swap,
  input  logic       cfg_inv_hi,
  input  logic       cfg_inv_lo,
  input  logic       cfg_own_hi,
  input  logic       cfg_own_lo,
  input  logic       cfg_ovr_en_hi,
  input  logic       cfg_ovr_en_lo,
  input  logic [1:0] cfg_ovr_val,
  input  logic       cfg_ovr_sync,
  input  logic [1:0] cfg_flt_val,
  input  logic       cfg_indep_flt,
  output logic       pin_hi,
  output logic       pin_lo,
  output logic       own_hi,
  output logic       own_lo
);
  localparam logic [1:0] M_COMP = 2'b00;
  localparam logic [1:0] M_RED  = 2'b01;
  localparam logic [1:0] M_PP   = 2'b10;
  localparam logic [1:0] M_IND  = 2'b11;

  logic [1:0] mode_q;
  logic       swap_q, inv_hi_q, inv_lo_q, own_hi_q, own_lo_q;
  logic [1:0] ovr_en_q, ovr_val_q;
  logic       pp_sel_q;
  logic       shp_hi, shp_lo, sw_hi, sw_lo, ov_hi, ov_lo, fl_hi, fl_lo;

  // frozen fields follow the inputs only while the channel is disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_COMP;
      swap_q   <= 1'b0;
      inv_hi_q <= 1'b0;
      inv_lo_q <= 1'b0;
      own_hi_q <= 1'b0;
      own_lo_q <= 1'b0;
    end else if (!enable) begin
      mode_q   <= cfg_mode;
      swap_q   <= cfg_swap;
      inv_hi_q <= cfg_inv_hi;
      inv_lo_q <= cfg_inv_lo;
      own_hi_q <= cfg_own_hi;
      own_lo_q <= cfg_own_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_en_q  <= 2'b00;
      ovr_val_q <= 2'b00;
    end else if (!cfg_ovr_sync || period_stb) begin
      ovr_en_q  <= {cfg_ovr_en_hi, cfg_ovr_en_lo};
      ovr_val_q <= cfg_ovr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           pp_sel_q <= 1'b0;
    else if (!enable)     pp_sel_q <= 1'b0;
    else if (period_stb)  pp_sel_q <= ~pp_sel_q;
  end

  always_comb begin
    unique case (mode_q)
      M_COMP:  begin shp_hi = gen_a;             shp_lo = ~gen_a;           end
      M_RED:   begin shp_hi = gen_a;             shp_lo = gen_a;            end
      M_PP:    begin shp_hi = gen_a & ~pp_sel_q; shp_lo = gen_a & pp_sel_q; end
      M_IND:   begin shp_hi = gen_a;             shp_lo = gen_b;            end
      default: begin shp_hi = 1'b0;              shp_lo = 1'b0;             end
    endcase
  end

  assign sw_hi = swap_q ? shp_lo : shp_hi;
  assign sw_lo = swap_q ? shp_hi : shp_lo;

  assign ov_hi = ovr_en_q[1] ? ovr_val_q[1] : sw_hi;
  assign ov_lo = ovr_en_q[0] ? ovr_val_q[0] : sw_lo;

  assign fl_hi = (cfg_indep_flt ? climit_in : fault_in) ? cfg_flt_val[1] : ov_hi;
  assign fl_lo = fault_in ? cfg_flt_val[0] : ov_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_hi <= 1'b0;
      pin_lo <= 1'b0;
    end else begin
      pin_hi <= fl_hi ^ inv_hi_q;
      pin_lo <= fl_lo ^ inv_lo_q;
    end
  end

  assign own_hi = own_hi_q;
  assign own_lo = own_lo_q;
endmodule

// File: rtl/pwm_pin_pair_cond_chk.sv
module pwm_pin_pair_cond_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       period_stb,
  input logic       fault_in,
  input logic       climit_in,
  input logic       cfg_ovr_sync,
  input logic [1:0] cfg_flt_val,
  input logic       cfg_indep_flt,
  input logic       pin_hi,
  input logic       pin_lo,
  input logic       own_hi,
  input logic       own_lo,
  input logic [1:0] mode_q,
  input logic       swap_q,
  input logic       inv_hi_q,
  input logic       inv_lo_q,
  input logic [1:0] ovr_en_q,
  input logic [1:0] ovr_val_q,
  input logic       pp_sel_q
);
  assert_reset_low_R14: assert property (@(posedge clk)
    !rst_n |-> (!pin_hi && !pin_lo && !own_hi && !own_lo));

  assert_cfg_frozen_R13: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> $stable({mode_q, swap_q, inv_hi_q, inv_lo_q}));

  assert_own_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    enable |=> ($stable(own_hi) && $stable(own_lo)));

  assert_ovr_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ovr_sync && !period_stb) |=> $stable({ovr_en_q, ovr_val_q}));

  assert_pp_home_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pp_sel_q);

  assert_fault_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_in && !cfg_indep_flt) |=>
      (pin_hi == ($past(cfg_flt_val[1]) ^ $past(inv_hi_q))) &&
      (pin_lo == ($past(cfg_flt_val[0]) ^ $past(inv_lo_q))));

  assert_climit_hi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (climit_in && cfg_indep_flt) |=>
      (pin_hi == ($past(cfg_flt_val[1]) ^ $past(inv_hi_q))));
endmodule

bind pwm_pin_pair_cond pwm_pin_pair_cond_chk chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .period_stb(period_stb),
  .fault_in(fault_in), .climit_in(climit_in), .cfg_ovr_sync(cfg_ovr_sync),
  .cfg_flt_val(cfg_flt_val), .cfg_indep_flt(cfg_indep_flt),
  .pin_hi(pin_hi), .pin_lo(pin_lo), .own_hi(own_hi), .own_lo(own_lo),
  .mode_q(mode_q), .swap_q(swap_q), .inv_hi_q(inv_hi_q), .inv_lo_q(inv_lo_q),
  .ovr_en_q(ovr_en_q), .ovr_val_q(ovr_val_q), .pp_sel_q(pp_sel_q)
);

// File: tb/pwm_pin_pair_cond_tb_top.sv
module pwm_pin_pair_cond_tb_top;
  logic clk = 1'b0;
  logic rst_n, enable, gen_a, gen_b, period_stb, fault_in, climit_in;
  logic [1:0] cfg_mode, cfg_ovr_val, cfg_flt_val;
  logic cfg_swap, cfg_inv_hi, cfg_inv_lo, cfg_own_hi, cfg_own_lo;
  logic cfg_ovr_en_hi, cfg_ovr_en_lo, cfg_ovr_sync, cfg_indep_flt;
  logic pin_hi, pin_lo, own_hi, own_lo;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwm_pin_pair_cond dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .gen_a(gen_a), .gen_b(gen_b),
    .period_stb(period_stb), .fault_in(fault_in), .climit_in(climit_in),
    .cfg_mode(cfg_mode), .cfg_swap(cfg_swap), .cfg_inv_hi(cfg_inv_hi),
    .cfg_inv_lo(cfg_inv_lo), .cfg_own_hi(cfg_own_hi), .cfg_own_lo(cfg_own_lo),
    .cfg_ovr_en_hi(cfg_ovr_en_hi), .cfg_ovr_en_lo(cfg_ovr_en_lo),
    .cfg_ovr_val(cfg_ovr_val), .cfg_ovr_sync(cfg_ovr_sync),
    .cfg_flt_val(cfg_flt_val), .cfg_indep_flt(cfg_indep_flt),
    .pin_hi(pin_hi), .pin_lo(pin_lo), .own_hi(own_hi), .own_lo(own_lo));

  // mode _ swap inv_hi inv_lo _ ovr_en_hi ovr_en_lo ovr_val[1:0]
  // _ flt_val[1:0] indep fault climit _ gen_a gen_b _ exp_hi exp_lo
  localparam int NV = 19;
  localparam logic [17:0] VEC [NV] = '{
    18'b00_000_0000_00000_10_10,  // R1
    18'b00_000_0000_00000_00_01,  // R1
    18'b01_000_0000_00000_10_11,  // R2
    18'b01_000_0000_00000_01_00,  // R2
    18'b11_000_0000_00000_01_01,  // R4
    18'b11_000_0000_00000_10_10,  // R4
    18'b10_000_0000_00000_10_10,  // R3 selector at home
    18'b00_010_0000_00000_10_00,  // R6
    18'b00_011_0000_00000_00_10,  // R6
    18'b00_100_0000_00000_10_01,  // R12
    18'b11_100_0000_00000_10_01,  // R12
    18'b00_000_1000_00000_10_00,  // R7
    18'b00_000_0101_00000_10_11,  // R7
    18'b00_000_0000_01010_10_01,  // R9
    18'b00_000_0000_01001_10_10,  // R9 climit ignored
    18'b00_000_0000_01101_10_00,  // R10 climit -> hi
    18'b00_000_0000_11110_10_11,  // R10 fault -> lo
    18'b00_010_1010_00010_00_10,  // R11 fault over override, polarity last
    18'b11_100_1010_00000_10_11   // R11 override after swap
  };
  localparam string VTAG [NV] = '{"R1","R1","R2","R2","R4","R4","R3","R6","R6",
    "R12","R12","R7","R7","R9","R9","R10","R10","R11","R11"};

  task automatic chk(input string tag, input logic ah, input logic al,
                     input logic eh, input logic el);
    checks++;
    if (ah !== eh || al !== el) begin
      errors++;
      $display("FAIL %s: got hi/lo=%b%b expected %b%b", tag, ah, al, eh, el);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; enable = 0; gen_a = 0; gen_b = 0; period_stb = 0;
    fault_in = 0; climit_in = 0; cfg_mode = 0; cfg_ovr_val = 0; cfg_flt_val = 0;
    cfg_swap = 0; cfg_inv_hi = 0; cfg_inv_lo = 0; cfg_own_hi = 0; cfg_own_lo = 0;
    cfg_ovr_en_hi = 0; cfg_ovr_en_lo = 0; cfg_ovr_sync = 0; cfg_indep_flt = 0;
    cfg_inv_hi = 1; gen_a = 1;
    wait_neg(3);
    chk("R14 pins", pin_hi, pin_lo, 1'b0, 1'b0);
    chk("R14 own", own_hi, own_lo, 1'b0, 1'b0);
    cfg_inv_hi = 0; gen_a = 0;
    rst_n = 1;
    wait_neg(2);

    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = VEC[i];
      {cfg_mode, cfg_swap, cfg_inv_hi, cfg_inv_lo, cfg_ovr_en_hi, cfg_ovr_en_lo,
       cfg_ovr_val, cfg_flt_val, cfg_indep_flt, fault_in, climit_in,
       gen_a, gen_b} = v[17:2];
      wait_neg(2);
      chk(VTAG[i], pin_hi, pin_lo, v[1], v[0]);
    end
    {cfg_mode, cfg_swap, cfg_inv_hi, cfg_inv_lo, cfg_ovr_en_hi, cfg_ovr_en_lo,
     cfg_ovr_val, cfg_flt_val, cfg_indep_flt, fault_in, climit_in, gen_a, gen_b} = '0;

    // R5 ownership
    cfg_own_hi = 1; cfg_own_lo = 0;
    wait_neg(2);
    chk("R5", own_hi, own_lo, 1'b1, 1'b0);

    // R13 frozen while enabled
    cfg_mode = 2'b01; gen_a = 1;
    wait_neg(2);
    enable = 1;
    wait_neg(1);
    cfg_mode = 2'b00; cfg_own_hi = 0; cfg_own_lo = 1; cfg_inv_lo = 1;
    wait_neg(4);
    chk("R13 pins", pin_hi, pin_lo, 1'b1, 1'b1);
    chk("R13 own", own_hi, own_lo, 1'b1, 1'b0);
    enable = 0;
    wait_neg(2);
    chk("R13 released", pin_hi, pin_lo, 1'b1, 1'b1);
    cfg_inv_lo = 0; cfg_own_lo = 0;

    // R3 push-pull alternation
    cfg_mode = 2'b10; gen_a = 1;
    wait_neg(2);
    enable = 1;
    wait_neg(2);
    chk("R3 start", pin_hi, pin_lo, 1'b1, 1'b0);
    period_stb = 1; wait_neg(1); period_stb = 0; wait_neg(1);
    chk("R3 flip1", pin_hi, pin_lo, 1'b0, 1'b1);
    wait_neg(3);
    chk("R3 hold", pin_hi, pin_lo, 1'b0, 1'b1);
    period_stb = 1; wait_neg(1); period_stb = 0; wait_neg(1);
    chk("R3 flip2", pin_hi, pin_lo, 1'b1, 1'b0);
    period_stb = 1; wait_neg(1); period_stb = 0;
    enable = 0;
    wait_neg(2);
    chk("R3 home", pin_hi, pin_lo, 1'b1, 1'b0);

    // R8 synchronised override
    cfg_mode = 2'b00;
    wait_neg(2);
    enable = 1;
    cfg_ovr_sync = 1; cfg_ovr_en_hi = 1; cfg_ovr_val = 2'b00;
    wait_neg(4);
    chk("R8 held", pin_hi, pin_lo, 1'b1, 1'b0);
    period_stb = 1; wait_neg(1); period_stb = 0; wait_neg(1);
    chk("R8 applied", pin_hi, pin_lo, 1'b0, 1'b0);
    cfg_ovr_sync = 0; cfg_ovr_en_hi = 0;
    wait_neg(2);
    chk("R8 unsynced", pin_hi, pin_lo, 1'b1, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule